// File: doc/BRIEF.md
# CAN Arbitrating Bit Transmitter

This block sends a CAN frame as a queue of raw bits that software has already stuffed and protected with a CRC. Software writes the bits one at a time into an internal bit queue. The block then waits for a trigger. Only the trigger chosen by the select input can start it: either the pulse that says the bus is free for a new frame, or the pulse that says a received bit pattern has matched. Each bit is held on the transmit line for one programmed bit period. At the programmed sample offset the block reads the bus. If it drove recessive and read dominant, it has lost arbitration. It then aborts, discards what is left of the queue and reports the loss.

When the block drives recessive, it watches for a falling edge on the bus after its own sample point. Such an edge comes from a faster sender that is already starting its next bit. The block then ends its current bit at once, so its bit timing stays aligned with that sender. To acknowledge a received frame, software selects the match trigger and queues one dominant bit. The block sends that bit when the match pulse arrives. The bit period and the sample offset are inputs, so they can be shared with the receive-side synchronizer settings.

Top module: `can_arb_tx`

## Requirements
- R1: After reset, `tx` is 1 (recessive), and `done` and `lost` are 0.
- R2: With `trig_sel`=0, only `permit_pulse` can start a frame. With `trig_sel`=1, only `match_pulse` can start a frame. The trigger that is not selected has no effect.
- R3: A selected trigger that arrives while the bit queue is empty is ignored, and `tx` stays 1.
- R4: The queued bits are driven on `tx` in write order. Each bit is held for `bit_period` cycles. The first bit appears in the cycle after the clock edge that captures the trigger.
- R5: When the last bit ends, `done` is high for exactly one cycle. For N bits with no resynchronisation, that cycle starts N×`bit_period` cycles after the trigger edge. From then on `tx` is 1.
- R6: The bus is read in the cycle where the bit counter equals `sample_off`, with the counter running from 0 at the start of each bit. If the block drives recessive there and `rx` is 0, `lost` is high for exactly one cycle in the next cycle. The frame stops, and `tx` is 1 from then on.
- R7: An abort empties the queue, so a later trigger starts nothing.
- R8: A dominant bit that reads back dominant is not a conflict. In acknowledge use, a single queued 0 is sent on `match_pulse` and completes with `done`.
- R9: If `rx` falls while the block drives recessive and the bit counter is past `sample_off`, the current bit ends in that cycle and the next bit starts in the following cycle.
- R10: The queue holds at least 128 bits. Writes made while it is full are dropped.
- R11: Within one bit, `tx` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_period | input | CW | Cycles per bit (at least 2) |
| sample_off | input | CW | Sample point inside the bit, below `bit_period` |
| wr_en | input | 1 | Write one bit into the queue |
| wr_bit | input | 1 | Bit value to queue (0 dominant, 1 recessive) |
| trig_sel | input | 1 | 0: transmit-permit starts; 1: match starts |
| permit_pulse | input | 1 | Bus-free pulse |
| match_pulse | input | 1 | Pattern-matched pulse |
| rx | input | 1 | Bus level as received |
| tx | output | 1 | Bus drive (1 recessive) |
| done | output | 1 | One-cycle pulse at end of a full frame |
| lost | output | 1 | One-cycle pulse when arbitration is lost |

## Verification
The bench checks the exact cycle of the arbitration loss for each bit position in a frame. A design that sampled one cycle off, or that let dominant-on-dominant count as a conflict, would report the loss in the wrong cycle or abort an acknowledge bit. After every loss the bench fires a new trigger and expects nothing to happen. A design that failed to flush the queue would send the bits that were left over. A short dominant glitch after the sample point must shorten the bit by exactly the remaining cycles. A design without resynchronisation finishes two cycles late, and one that resynchronises before the sample point aborts instead of finishing. Overfilling the queue must send exactly the queue depth of bits. The bench also fires triggers with an empty queue and fires the trigger that was not selected, and expects both to be ignored.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
   typedef enum logic [0:0] {
      TXS_IDLE = 1'b0,
      TXS_SEND = 1'b1
   } txs_e;

   localparam logic BUS_RECESSIVE = 1'b1;
   localparam logic BUS_DOMINANT  = 1'b0;
endpackage

// File: rtl/can_txbit_fifo.sv
module can_txbit_fifo #(
   parameter int DEPTH = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic rd_en,
   output logic rd_bit,
   output logic empty,
   output logic full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW = $clog2(DEPTH + 1);
   localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
   localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

   logic [DEPTH-1:0] mem;
   logic [PW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [LW-1:0]    level;
   logic             wr_ok, rd_ok;

   assign empty  = (level == '0);
   assign full   = (level == LVL_MAX);
   assign wr_ok  = wr_en & ~full & ~flush;
   assign rd_ok  = rd_en & ~empty & ~flush;
   assign rd_bit = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_cmp_wrap
         assign wp_nx = (wp == PTR_LAST) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_LAST) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (wr_ok) wp <= wp_nx;
         if (rd_ok) rp <= rp_nx;
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_bit;
   end

   // R10
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_MAX);

   // R10
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/can_tx_bittimer.sv
module can_tx_bittimer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          restart,
   input  logic [CW-1:0] period,
   input  logic [CW-1:0] samp_off,
   input  logic          rx,
   input  logic          drive_rec,
   output logic [CW-1:0] cnt,
   output logic          at_sample,
   output logic          at_end
);
   logic rx_q;
   logic rx_fall;
   logic late_edge;

   assign rx_fall   = rx_q & ~rx;
   assign late_edge = run & drive_rec & rx_fall & (cnt > samp_off);
   assign at_sample = run & (cnt == samp_off);
   assign at_end    = run & ((cnt == period - 1'b1) | late_edge);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         rx_q <= 1'b1;
      end else begin
         rx_q <= rx;
         if (restart || !run) cnt <= '0;
         else                 cnt <= cnt + 1'b1;
      end
   end

   // R9
   resync_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_end && cnt != period - 1'b1) |-> (cnt > samp_off && drive_rec && !rx));
endmodule

// File: rtl/can_arb_tx.sv
module can_arb_tx
   import can_tx_pkg::*;
#(
   parameter int DEPTH = 128,
   parameter int CW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] bit_period,
   input  logic [CW-1:0] sample_off,
   input  logic          wr_en,
   input  logic          wr_bit,
   input  logic          trig_sel,
   input  logic          permit_pulse,
   input  logic          match_pulse,
   input  logic          rx,
   output logic          tx,
   output logic          done,
   output logic          lost
);
   generate
      if (DEPTH < 128) begin : g_bad_depth
         $error("can_arb_tx: DEPTH must be at least 128");
      end
      if (CW < 2) begin : g_bad_cw
         $error("can_arb_tx: CW must be at least 2");
      end
   endgenerate

   txs_e          st;
   logic          cur_bit;
   logic          trig, start, advance, conflict, pop, flush;
   logic          q_bit, q_empty, q_full;
   logic [CW-1:0] cnt;
   logic          at_sample, at_end;
   logic          sending;

   assign sending  = (st == TXS_SEND);
   assign trig     = trig_sel ? match_pulse : permit_pulse;
   assign start    = !sending && trig && !q_empty;
   assign conflict = sending && at_sample && (cur_bit == BUS_RECESSIVE) && (rx == BUS_DOMINANT);
   assign advance  = sending && !conflict && at_end && !q_empty;
   assign pop      = start || advance;
   assign flush    = conflict;
   assign tx       = sending ? cur_bit : BUS_RECESSIVE;

   can_txbit_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .wr_en  (wr_en),
      .wr_bit (wr_bit),
      .rd_en  (pop),
      .rd_bit (q_bit),
      .empty  (q_empty),
      .full   (q_full)
   );

   can_tx_bittimer #(.CW(CW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (sending),
      .restart   (pop),
      .period    (bit_period),
      .samp_off  (sample_off),
      .rx        (rx),
      .drive_rec (cur_bit),
      .cnt       (cnt),
      .at_sample (at_sample),
      .at_end    (at_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= TXS_IDLE;
         cur_bit <= BUS_RECESSIVE;
         done    <= 1'b0;
         lost    <= 1'b0;
      end else begin
         done <= 1'b0;
         lost <= 1'b0;
         if (pop) cur_bit <= q_bit;
         case (st)
            TXS_IDLE: if (start) st <= TXS_SEND;
            TXS_SEND: begin
               if (conflict) begin
                  lost <= 1'b1;
                  st   <= TXS_IDLE;
               end else if (at_end && q_empty) begin
                  done <= 1'b1;
                  st   <= TXS_IDLE;
               end
            end
            default: st <= TXS_IDLE;
         endcase
      end
   end

   // R5
   done_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> tx);

   // R6
   lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lost |-> ($past(tx) && !$past(rx) && tx));

   // R7
   lost_flushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lost |-> q_empty);

   // R11
   bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && $past(sending) && cnt != '0) |-> $stable(tx));

   // R5
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && lost));
endmodule

// File: tb/can_arb_tx_tb.sv
module can_arb_tx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 128;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] bit_period = 8'd6;
   logic [CW-1:0] sample_off = 8'd3;
   logic wr_en = 1'b0, wr_bit = 1'b1, trig_sel = 1'b0;
   logic permit_pulse = 1'b0, match_pulse = 1'b0;
   logic other = 1'b1;
   logic rx, tx, done, lost;

   assign rx = tx & other;

   can_arb_tx #(.DEPTH(DEPTH), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .sample_off(sample_off),
      .wr_en(wr_en), .wr_bit(wr_bit), .trig_sel(trig_sel),
      .permit_pulse(permit_pulse), .match_pulse(match_pulse),
      .rx(rx), .tx(tx), .done(done), .lost(lost)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_run = 0, n_fail = 0;
   logic [255:0] frm;
   int nb = 0, per = 6;
   int drop_at = -100, drop_len = 0;
   int d_at, l_at, txerr, dcnt;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_frame();
      for (int j = 0; j < nb; j++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_bit = frm[j];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fire(input bit use_match);
      @(negedge clk);
      if (use_match) match_pulse = 1'b1;
      else permit_pulse = 1'b1;
   endtask

   // mode 0: observe only, 1: expect frame bits then recessive, 2: expect recessive
   task automatic watch(input int maxc, input int mode);
      d_at = -1; l_at = -1; txerr = 0; dcnt = 0;
      for (int idx = 0; idx < maxc; idx++) begin
         @(negedge clk);
         permit_pulse = 1'b0;
         match_pulse = 1'b0;
         other = !(idx >= drop_at && idx < drop_at + drop_len);
         #1;
         if (done) dcnt++;
         if (done && d_at < 0) d_at = idx;
         if (lost && l_at < 0) l_at = idx;
         if (mode == 1 && idx < nb * per && tx !== frm[idx / per]) txerr++;
         if (mode == 1 && idx >= nb * per && tx !== 1'b1) txerr++;
         if (mode == 2 && tx !== 1'b1) txerr++;
      end
      other = 1'b1;
   endtask

   task automatic set_timing(input int p, input int s);
      per = p;
      bit_period = CW'(p);
      sample_off = CW'(s);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      // R1
      check(tx === 1'b1 && done === 1'b0 && lost === 1'b0, "R1 reset", {tx, done, lost}, 3'b100);
      rst_n = 1'b1;

      // R3: empty queue trigger ignored
      set_timing(6, 3);
      fire(1'b0);
      watch(20, 2);
      check(txerr == 0 && d_at < 0, "R3 empty trigger", txerr, 0);

      // R2: unselected trigger ignored, selected one starts
      trig_sel = 1'b0;
      nb = 3; frm = '0; frm[0] = 1'b0; frm[1] = 1'b1; frm[2] = 1'b0;
      push_frame();
      fire(1'b1);
      watch(3 * per + 2, 2);
      check(txerr == 0 && d_at < 0, "R2 match ignored in permit mode", txerr, 0);
      fire(1'b0);
      watch(nb * per + 3, 1);
      check(txerr == 0, "R2 permit starts frame", txerr, 0);
      check(d_at == nb * per, "R5 done timing", d_at, nb * per);

      // R4/R5 sweep over bit periods and patterns
      for (int pi = 0; pi < 3; pi++) begin
         for (int pat = 0; pat < 4; pat++) begin
            int p;
            p = (pi == 0) ? 4 : (pi == 1) ? 6 : 9;
            set_timing(p, p / 2);
            nb = 5 + pat * 3;
            frm = '0;
            for (int j = 0; j < nb; j++) frm[j] = (((j * (pat + 3) + pat) % 5) < 2) ? 1'b0 : 1'b1;
            push_frame();
            fire(1'b0);
            watch(nb * per + 4, 1);
            check(txerr == 0, "R4 bit order and length", txerr, 0);
            check(d_at == nb * per, "R5 done cycle", d_at, nb * per);
            check(dcnt == 1 && l_at < 0, "R5 single done pulse", dcnt, 1);
         end
      end

      // R8: acknowledge bit on match pulse
      set_timing(6, 3);
      trig_sel = 1'b1;
      nb = 1; frm = '0;
      push_frame();
      fire(1'b0);
      watch(10, 2);
      check(txerr == 0 && d_at < 0, "R2 permit ignored in match mode", txerr, 0);
      drop_at = 0; drop_len = 6;
      fire(1'b1);
      watch(9, 1);
      drop_at = -100; drop_len = 0;
      check(txerr == 0 && l_at < 0, "R8 ack bit sent, no conflict", txerr, 0);
      check(d_at == 6, "R8 ack done", d_at, 6);
      trig_sel = 1'b0;

      // R6/R7: loss at each position
      for (int pos = 0; pos < 6; pos++) begin
         set_timing(6, 2);
         nb = 8; frm = '1;
         push_frame();
         drop_at = pos * per; drop_len = per;
         fire(1'b0);
         watch(pos * per + per + 2, 0);
         drop_at = -100; drop_len = 0;
         check(l_at == pos * per + 2 + 1, "R6 loss cycle", l_at, pos * per + 3);
         check(d_at < 0, "R6 no done after loss", d_at, -1);
         fire(1'b0);
         watch(20, 2);
         check(txerr == 0 && d_at < 0, "R7 queue flushed", txerr, 0);
      end

      // R9: resync to a faster sender edge after the sample point
      set_timing(8, 3);
      nb = 3; frm = '1;
      push_frame();
      drop_at = 5; drop_len = 1;
      fire(1'b0);
      watch(30, 0);
      drop_at = -100; drop_len = 0;
      check(d_at == 22 && l_at < 0, "R9 resync shortens bit", d_at, 22);

      // R10: overfill drops extra writes
      set_timing(4, 1);
      nb = 130; frm = '1;
      push_frame();
      fire(1'b0);
      watch(DEPTH * 4 + 20, 0);
      check(d_at == DEPTH * 4, "R10 depth limit", d_at, DEPTH * 4);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule